// File: doc/BRIEF.md
# Serial EEPROM Slave Controller

This block is the slave end of a four-wire serial EEPROM. It holds a behavioural byte array and a status register. A host reaches both through commands framed by an active-low select line. The supported commands set and clear a write-enable latch, read and write the status register, read the array sequentially, and load one or more bytes for writing.

Data bytes for a write are gathered in a one-page buffer. The array itself is not touched until the select line rises exactly at a byte boundary. When that happens, the buffered bytes are committed and a self-timed programming interval starts. The interval is counted in system clocks and reported through a busy bit in the status register.

The serial pins are brought into the system clock domain through synchronisers. All protocol state advances on detected edges. This means SCK must run well below the system clock: each SCK half period should be at least four system clocks.

Top module: `spi_eeprom_slave`

## Requirements
- R1: Framing follows SPI mode 0. MOSI is sampled on the rising SCK edge, most significant bit first. The command byte is followed by a 16-bit address, high byte first. Opcodes: 06h set latch, 04h clear latch, 05h read status, 01h write status, 03h read array, 02h write array; every other opcode is ignored.
- R2: MISO changes only after a falling SCK edge or a deselect. The first output bit (bit 7) appears on the fall that follows the last command or address bit. MISO is 0 whenever no output byte is being shifted.
- R3: A write cycle begins only when select rises after a whole number of data bytes, and at least one byte. Deselecting at any other point cancels the write and leaves both the array and the latch unchanged.
- R4: Write data fills a 64-byte page. It starts at the addressed byte, and the low six address bits wrap from 63 to 0 within the same page. A later byte that lands on an already loaded location replaces it. Only loaded locations are committed.
- R5: Status byte layout: bit 0 busy, bit 1 write-enable latch, bits 2, 3 and 7 writable, all other bits 0. The reset value is 00h. A write-status command stores the byte masked with 8Ch when select rises on a byte boundary, and also runs a timed cycle.
- R6: The busy bit reads 1 for PROG_CYCLES system clocks after a write starts, then reads 0. The latch is cleared at the same time.
- R7: Write-array and write-status commands are ignored while the latch is 0.
- R8: While busy, read-array and write-array commands are ignored (MISO stays 0) and the running cycle continues unchanged. Status reads still work.
- R9: After a set-latch, clear-latch or read-status command completes, further SCK edges are ignored until select rises.
- R10: After reset the block is deselected. A falling edge on select is needed before any command is accepted, and SCK activity while select is high has no effect.
- R11: Every array byte resets to FFh. A read streams bytes from consecutive addresses for as long as SCK runs.

Top module port order below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |

## Verification
A corrupted frame state shows up as a wrong MISO byte in the very next read frame. It also shows up as a status value with wrong latch or busy bits, visible within one status poll of about 16 SCK periods. A lost or misplaced page-buffer entry is only visible after the timed cycle ends, when the array is read back. For this reason the bench always reads back after polling the busy bit down, and it checks both wrapped and untouched neighbouring locations. Errors in the lockout logic appear at once as non-zero read data during the busy interval, or later as an unexpected array change.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_CMD, ST_ADDR, ST_DATA, ST_RD, ST_SR, ST_WSR, ST_WAIT
    } ee_state_e;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;

    localparam logic [7:0] SR_WMASK = 8'h8C;
endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
    parameter int W = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= RST_VAL;
            else        stg[s] <= (s == 0) ? din : stg[(s == 0) ? 0 : s - 1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/spi_ee_array.sv
module spi_ee_array #(
    parameter int MEM_BYTES  = 512,
    parameter int PAGE_BYTES = 64,
    localparam int IDX_W = $clog2(MEM_BYTES),
    localparam int PTR_W = $clog2(PAGE_BYTES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [IDX_W-1:0]              raddr,
    output logic [7:0]                    rdata,
    input  logic                          commit,
    input  logic [IDX_W-PTR_W-1:0]        wpage,
    input  logic [PAGE_BYTES-1:0][7:0]    wdata,
    input  logic [PAGE_BYTES-1:0]         wvalid
);
    logic [7:0] mem [MEM_BYTES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
        end else if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++)
                if (wvalid[i]) mem[{wpage, PTR_W'(i)}] <= wdata[i];
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave #(
    parameter int MEM_BYTES   = 512,
    parameter int PAGE_BYTES  = 64,
    parameter int PROG_CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso
);
    import spi_ee_pkg::*;

    localparam int IDX_W = $clog2(MEM_BYTES);
    localparam int PTR_W = $clog2(PAGE_BYTES);
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);

    typedef struct packed {
        ee_state_e                 st;
        logic [2:0]                bitc;
        logic [7:0]                sh;
        logic [7:0]                op;
        logic                      abyte;
        logic [15:0]               addr;
        logic [PTR_W-1:0]          ptr;
        logic [7:0]                obuf;
        logic                      miso;
        logic                      wel;
        logic [7:0]                srbits;
        logic                      busy;
        logic [CNT_W-1:0]          cnt;
        logic                      commit;
        logic                      got;
        logic                      sck_p;
        logic                      cs_p;
        logic [PAGE_BYTES-1:0][7:0] pbuf;
        logic [PAGE_BYTES-1:0]     pval;
    } regs_t;

    regs_t q, d;

    logic [2:0] pins_s;
    logic       sck_s, cs_s, mosi_s;
    logic       cs_fall, cs_rise, sck_rise, sck_fall, active;
    logic [7:0] in_byte, rdata, status;

    spi_ee_sync #(.W(3), .STAGES(2), .RST_VAL(3'b010)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .din({spi_sck, spi_cs_n, spi_mosi}), .dout(pins_s)
    );
    assign {sck_s, cs_s, mosi_s} = pins_s;

    spi_ee_array #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_array (
        .clk(clk), .rst_n(rst_n),
        .raddr(q.addr[IDX_W-1:0]), .rdata(rdata),
        .commit(q.commit), .wpage(q.addr[IDX_W-1:PTR_W]),
        .wdata(q.pbuf), .wvalid(q.pval)
    );

    assign cs_fall  = q.cs_p & ~cs_s;
    assign cs_rise  = ~q.cs_p & cs_s;
    assign sck_rise = ~q.sck_p & sck_s & ~cs_s;
    assign sck_fall = q.sck_p & ~sck_s & ~cs_s;
    assign active   = (q.st != ST_IDLE) && (q.st != ST_WAIT);
    assign in_byte  = {q.sh[6:0], mosi_s};
    assign status   = q.srbits | {6'b0, q.wel, q.busy};

    always_comb begin
        d = q;
        d.commit = 1'b0;
        d.sck_p  = sck_s;
        d.cs_p   = cs_s;
        if (q.busy) begin
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CNT_W'(1)) begin
                d.busy = 1'b0;
                d.wel  = 1'b0;
            end
        end
        if (cs_rise) begin
            if (q.bitc == 3'd0 && q.got && q.st == ST_DATA) begin
                d.busy   = 1'b1;
                d.cnt    = CNT_W'(PROG_CYCLES);
                d.commit = 1'b1;
            end
            if (q.bitc == 3'd0 && q.got && q.st == ST_WSR) begin
                d.busy   = 1'b1;
                d.cnt    = CNT_W'(PROG_CYCLES);
                d.srbits = q.sh & SR_WMASK;
            end
            d.st   = ST_IDLE;
            d.miso = 1'b0;
        end else if (cs_fall) begin
            d.st    = ST_CMD;
            d.bitc  = 3'd0;
            d.got   = 1'b0;
            d.abyte = 1'b0;
        end else if (sck_rise && active) begin
            d.sh   = in_byte;
            d.bitc = q.bitc + 3'd1;
            if (q.bitc == 3'd7) begin
                case (q.st)
                    ST_CMD: begin
                        d.op = in_byte;
                        case (in_byte)
                            OP_WREN:  begin d.wel = 1'b1; d.st = ST_WAIT; end
                            OP_WRDI:  begin d.wel = 1'b0; d.st = ST_WAIT; end
                            OP_RDSR:  d.st = ST_SR;
                            OP_WRSR:  d.st = (q.wel && !q.busy) ? ST_WSR : ST_WAIT;
                            OP_READ:  d.st = !q.busy ? ST_ADDR : ST_WAIT;
                            OP_WRITE: d.st = (q.wel && !q.busy) ? ST_ADDR : ST_WAIT;
                            default:  d.st = ST_WAIT;
                        endcase
                    end
                    ST_ADDR: begin
                        if (!q.abyte) begin
                            d.addr[15:8] = in_byte;
                            d.abyte      = 1'b1;
                        end else begin
                            d.addr[7:0] = in_byte;
                            if (q.op == OP_READ) begin
                                d.st = ST_RD;
                            end else begin
                                d.st   = ST_DATA;
                                d.pval = '0;
                                d.ptr  = in_byte[PTR_W-1:0];
                            end
                        end
                    end
                    ST_DATA: begin
                        d.pbuf[q.ptr] = in_byte;
                        d.pval[q.ptr] = 1'b1;
                        d.ptr         = q.ptr + 1'b1;
                        d.got         = 1'b1;
                    end
                    ST_RD:   d.addr = q.addr + 16'd1;
                    ST_SR:   d.st   = ST_WAIT;
                    ST_WSR:  d.got  = 1'b1;
                    default: ;
                endcase
            end
        end else if (sck_fall) begin
            if (q.st == ST_RD || q.st == ST_SR) begin
                if (q.bitc == 3'd0) begin
                    d.obuf = (q.st == ST_RD) ? rdata : status;
                    d.miso = d.obuf[7];
                end else begin
                    d.miso = q.obuf[3'd7 - q.bitc];
                end
            end else begin
                d.miso = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.sck_p <= 1'b0;
            q.cs_p  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign spi_miso = q.miso;

    ee_state_e st_w;
    logic      busy_w, wel_w;
    assign st_w   = q.st;
    assign busy_w = q.busy;
    assign wel_w  = q.wel;
endmodule

// File: rtl/spi_ee_check.sv
module spi_ee_check
    import spi_ee_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      cs_rise,
    input logic      cs_fall,
    input logic      sck_fall,
    input ee_state_e st,
    input logic      busy,
    input logic      wel,
    input logic      miso
);
    assert_busy_starts_at_deselect_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cs_rise));

    assert_latch_cleared_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);

    assert_no_array_cmd_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ADDR && $past(st) == ST_CMD) |-> !$past(busy));

    assert_miso_moves_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sck_fall || cs_rise) |-> $stable(miso));

    assert_wait_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == ST_WAIT && !$past(cs_rise)) |-> st == ST_WAIT);

    assert_start_needs_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == ST_IDLE && st != ST_IDLE) |-> $past(cs_fall));
endmodule

bind spi_eeprom_slave spi_ee_check u_chk (
    .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .cs_fall(cs_fall),
    .sck_fall(sck_fall), .st(st_w), .busy(busy_w), .wel(wel_w), .miso(spi_miso)
);

// File: tb/sim_spi_eeprom_slave.sv
module sim_spi_eeprom_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso;

    int n_checks = 0, n_fail = 0;
    logic [7:0] exp_q [$];
    string      req_q [$];
    logic [7:0] got_q [$];
    logic [7:0] wdata [80];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_eeprom_slave #(.PROG_CYCLES(2000)) u0 (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    // scoreboard monitor: compare each captured read byte against the queue
    always @(negedge clk) begin
        if (got_q.size() > 0) begin
            logic [7:0] g;
            g = got_q.pop_front();
            if (exp_q.size() == 0) check("scoreboard", g, 8'hxx);
            else check(req_q.pop_front(), g, exp_q.pop_front());
        end
    end

    task automatic expect_byte(input string req, input logic [7:0] v);
        req_q.push_back(req);
        exp_q.push_back(v);
    endtask

    task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - n; i--) begin
            mosi = tx[i];
            repeat (HALF) @(posedge clk);
            #1 rx[i] = miso;
            sck = 1'b1;
            repeat (HALF) @(posedge clk);
            #1 sck = 1'b0;
        end
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        spi_bits(tx, 8, rx);
    endtask

    task automatic sel();
        #1 cs_n = 1'b0;
        repeat (HALF) @(posedge clk);
    endtask

    task automatic desel();
        repeat (HALF) @(posedge clk);
        #1 cs_n = 1'b1;
        repeat (4 * HALF) @(posedge clk);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] r;
        sel(); spi_byte(op, r); desel();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] r;
        sel(); spi_byte(8'h05, r); spi_byte(8'h00, s); desel();
    endtask

    task automatic read_chk(input logic [15:0] a, input int n);
        logic [7:0] r;
        sel();
        spi_byte(8'h03, r); spi_byte(a[15:8], r); spi_byte(a[7:0], r);
        for (int i = 0; i < n; i++) begin
            spi_byte(8'h00, r);
            got_q.push_back(r);
        end
        desel();
    endtask

    task automatic wr(input logic [15:0] a, input int n, input int extra);
        logic [7:0] r;
        sel();
        spi_byte(8'h02, r); spi_byte(a[15:8], r); spi_byte(a[7:0], r);
        for (int i = 0; i < n; i++) spi_byte(wdata[i], r);
        if (extra > 0) spi_bits(8'hA0, extra, r);
        desel();
    endtask

    task automatic wait_done(input string req);
        logic [7:0] s;
        s = 8'h01;
        for (int i = 0; i < 40 && s[0]; i++) rdsr(s);
        check(req, {7'b0, s[0]}, 8'h00);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] s, r;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (5) @(posedge clk);

        // R10: reset state, SCK with select high is ignored
        check("R10 miso idle", {7'b0, miso}, 8'h00);
        spi_byte(8'h06, r);
        repeat (4 * HALF) @(posedge clk);
        rdsr(s); check("R10 no command while deselected", s, 8'h00);
        check("R5 reset status", s, 8'h00);

        // R11: erased array and sequential read
        expect_byte("R11 erased 0010", 8'hFF);
        expect_byte("R11 erased 0011", 8'hFF);
        read_chk(16'h0010, 2);

        // R7: write with latch clear is ignored
        wdata[0] = 8'h11;
        wr(16'h0040, 1, 0);
        rdsr(s); check("R7 no cycle without latch", s, 8'h00);
        expect_byte("R7 array untouched", 8'hFF);
        read_chk(16'h0040, 1);

        // R1: set and clear latch
        cmd1(8'h06); rdsr(s); check("R1 set latch", s, 8'h02);
        cmd1(8'h04); rdsr(s); check("R1 clear latch", s, 8'h00);
        cmd1(8'h5A); rdsr(s); check("R1 unknown opcode ignored", s, 8'h00);

        // R3/R6: byte write
        cmd1(8'h06);
        wdata[0] = 8'hA5;
        wr(16'h0040, 1, 0);
        rdsr(s); check("R6 busy and latch during cycle", s, 8'h03);
        wait_done("R6 cycle ends");
        rdsr(s); check("R6 latch cleared", s, 8'h00);
        expect_byte("R3 byte written", 8'hA5);
        read_chk(16'h0040, 1);

        // R3: deselect off a byte boundary cancels
        cmd1(8'h06);
        wdata[0] = 8'h3C;
        wr(16'h0050, 1, 3);
        rdsr(s); check("R3 partial byte cancels", s, 8'h02);
        wr(16'h0051, 0, 0);
        rdsr(s); check("R3 no data byte cancels", s, 8'h02);
        expect_byte("R3 cancelled write", 8'hFF);
        read_chk(16'h0050, 1);

        // R4: wrap within page, overwrite of loaded byte
        for (int i = 0; i < 4; i++) wdata[i] = 8'(i + 1);
        wr(16'h007E, 4, 0);
        wait_done("R4 wrap cycle");
        expect_byte("R4 7D untouched", 8'hFF);
        expect_byte("R4 7E", 8'h01);
        expect_byte("R4 7F", 8'h02);
        read_chk(16'h007D, 3);
        expect_byte("R4 wrapped 40", 8'h03);
        expect_byte("R4 wrapped 41", 8'h04);
        expect_byte("R4 42 untouched", 8'hFF);
        read_chk(16'h0040, 3);

        cmd1(8'h06);
        for (int i = 0; i < 65; i++) wdata[i] = 8'(8'h10 + i);
        wr(16'h0080, 65, 0);
        wait_done("R4 full page cycle");
        expect_byte("R4 reloaded 80", 8'h50);
        expect_byte("R4 81", 8'h11);
        read_chk(16'h0080, 2);
        expect_byte("R4 BF", 8'h4F);
        expect_byte("R11 next page C0", 8'hFF);
        read_chk(16'h00BF, 2);

        // R8: lockout during cycle
        cmd1(8'h06);
        wdata[0] = 8'h77;
        wr(16'h00C0, 1, 0);
        expect_byte("R8 read ignored while busy", 8'h00);
        read_chk(16'h00C0, 1);
        cmd1(8'h06);
        wdata[0] = 8'h99;
        wr(16'h00C1, 1, 0);
        rdsr(s); check("R8 status readable while busy", s, 8'h03);
        wait_done("R8 cycle completes");
        expect_byte("R8 cycle data", 8'h77);
        expect_byte("R8 write ignored while busy", 8'hFF);
        read_chk(16'h00C0, 2);

        // R9: wait state after commands
        sel(); spi_byte(8'h06, r); spi_byte(8'h04, r); desel();
        rdsr(s); check("R9 clocks after set latch ignored", s, 8'h02);
        sel(); spi_byte(8'h05, r); spi_byte(8'h00, s); spi_byte(8'h00, r); desel();
        check("R9 status byte", s, 8'h02);
        check("R9 no second status byte", r, 8'h00);
        cmd1(8'h04);

        // R5/R7: write status
        sel(); spi_byte(8'h01, r); spi_byte(8'hFF, r); desel();
        rdsr(s); check("R7 write status ignored", s, 8'h00);
        cmd1(8'h06);
        sel(); spi_byte(8'h01, r); spi_byte(8'hFF, r); desel();
        rdsr(s); check("R5 status write runs cycle", s, 8'h8F);
        wait_done("R5 status cycle");
        rdsr(s); check("R5 masked status kept", s, 8'h8C);

        repeat (20) @(posedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule